// File: doc/BRIEF.md
# Digit-Serial Add/Subtract Engine

This block adds or subtracts two unsigned operands using a single narrow adder. The operands are split into digits of `DIGIT_W` bits, and the block handles one digit per clock, starting with the least significant. One carry flip-flop is both the carry into the adder and the carry out of it, so the carry of each digit step feeds the next.

Subtraction uses the same adder. Each subtrahend digit is inverted before it enters the adder, and the carry is set to 1 before the first digit. At the end, the final carry is inverted so that the flag output reads as a borrow. With the default parameters, the block works on 16-bit operands in four 4-bit steps.

A caller pulses `start_i` while the engine is idle, with the operands and the operation select valid in that cycle. The engine reports `busy_o` while it works and raises `done_o` for one cycle when the sum and flag are complete. The sum and flag then stay unchanged until the next accepted start.

Top module: `serial_addsub`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `busy_o`, `done_o`, `sum_o` and `cy_bw_o` are all 0.
- R2: A `start_i` sampled high while idle is accepted at that clock edge. `busy_o` is then high for exactly `NUM_DIGITS` cycles, one per digit, handled least significant first.
- R3: `done_o` is high for exactly one cycle, the cycle right after the last `busy_o` cycle. `busy_o` and `done_o` are never high together.
- R4: With `sub_i` = 0 (add), `sum_o` = (A + B) mod 2^WIDTH. `cy_bw_o` = 1 exactly when A + B ≥ 2^WIDTH; the carry starts at 0.
- R5: With `sub_i` = 1 (subtract), `sum_o` = (A − B) mod 2^WIDTH. `cy_bw_o` = 1 (borrow) exactly when A < B. The carry starts at 1, the subtrahend digits are inverted, and the flag is the inverted final carry.
- R6: The carry chains through every digit. Examples: all-ones digits with carry 1 pass the carry on (0xFFFF + 0x0001 = 0x0000, flag 1). All-zero inverted digits with carry 0 pass the borrow on (0x0000 − 0x0001 = 0xFFFF, flag 1). Also 0x20F4 − 0x0A18 = 0x16DC with flag 0, and 0x2E83 + 0xA70F = 0xD592 with flag 0.
- R7: A `start_i` while `busy_o` is high is ignored. The running operation finishes on its normal schedule with its own operands and operation.
- R8: After `done_o`, `sum_o` and `cy_bw_o` hold their values until the next accepted start, whatever `a_i`, `b_i` and `sub_i` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| start_i | input | 1 | Start request, taken only when idle |
| sub_i | input | 1 | Operation: 0 = add, 1 = subtract |
| a_i | input | WIDTH | First operand (augend or minuend) |
| b_i | input | WIDTH | Second operand (addend or subtrahend) |
| busy_o | output | 1 | High while digits are being processed |
| done_o | output | 1 | One-cycle completion pulse |
| sum_o | output | WIDTH | Sum or difference |
| cy_bw_o | output | 1 | Carry after add, borrow after subtract |

## Verification
The bench builds two instances. The first uses 2-bit digits and three steps, giving 6-bit operands. At that size, every operand pair in both operations can be swept with arithmetic expected values, so every carry and borrow chain length and every step-timing case are covered. The second instance keeps the defaults of 4-bit digits and four steps. It runs the long propagation examples, the start-while-busy case and the hold-after-done case on full 16-bit operands.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } st_e;
endpackage

// File: rtl/digit_adder.sv
// Ripple-carry adder over one digit, built from a chain of 1-bit full adders.
module digit_adder #(
  parameter int DW = 4
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          c_i,
  output logic [DW-1:0] s_o,
  output logic          c_o
);
  logic [DW:0] chain;

  assign chain[0] = c_i;

  for (genvar k = 0; k < DW; k++) begin : g_fa
    assign s_o[k]     = a_i[k] ^ b_i[k] ^ chain[k];
    assign chain[k+1] = (a_i[k] & b_i[k]) | (chain[k] & (a_i[k] ^ b_i[k]));
  end

  assign c_o = chain[DW];
endmodule

// File: rtl/digit_shifter.sv
// Operand store: loaded in parallel, then shifted one digit per step,
// so the low digit is always the one being processed.
module digit_shifter #(
  parameter int DW = 4,
  parameter int ND = 4,
  localparam int W = DW * ND
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          shift_i,
  input  logic [W-1:0]  d_i,
  output logic [DW-1:0] dig_o
);
  logic [W-1:0] q_r, q_n;
  logic         en;

  always_comb begin
    en  = load_i | shift_i;
    q_n = q_r;
    if (load_i)       q_n = d_i;
    else if (shift_i) q_n = W'(q_r >> DW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '0;
    else if (en) q_r <= q_n;
  end

  assign dig_o = q_r[DW-1:0];
endmodule

// File: rtl/step_ctrl.sv
// Sequencer: idle/run state and digit counter.
module step_ctrl #(
  parameter int ND = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic accept_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  import addsub_pkg::*;

  localparam int CNT_W = (ND > 1) ? $clog2(ND) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ND - 1);

  st_e              st_r, st_n;
  logic [CNT_W-1:0] cnt_r, cnt_n;
  logic             done_r, done_n;
  logic             last;

  always_comb begin
    accept_o = (st_r == ST_IDLE) && start_i;
    step_o   = (st_r == ST_RUN);
    last     = step_o && (cnt_r == LAST);
    st_n     = st_r;
    cnt_n    = cnt_r;
    done_n   = 1'b0;
    unique case (st_r)
      ST_IDLE: begin
        if (start_i) begin
          st_n  = ST_RUN;
          cnt_n = '0;
        end
      end
      ST_RUN: begin
        if (last) begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
        end else begin
          cnt_n = cnt_r + 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_r   <= ST_IDLE;
      cnt_r  <= '0;
      done_r <= 1'b0;
    end else begin
      st_r   <= st_n;
      cnt_r  <= cnt_n;
      done_r <= done_n;
    end
  end

  assign busy_o = step_o;
  assign done_o = done_r;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R3
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy_o, done_o})); // R3
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(busy_o)); // R2
endmodule

// File: rtl/serial_addsub.sv
module serial_addsub #(
  parameter int DIGIT_W    = 4,
  parameter int NUM_DIGITS = 4,
  localparam int WIDTH     = DIGIT_W * NUM_DIGITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             sub_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] sum_o,
  output logic             cy_bw_o
);
  import addsub_pkg::*;

  logic               accept, step;
  logic [DIGIT_W-1:0] a_dig, b_dig, b_eff, s_dig;
  logic               c_out;

  op_e                op_r, op_n;
  logic               cy_r, cy_n, cy_en;
  logic [WIDTH-1:0]   res_r, res_n;

  step_ctrl #(.ND(NUM_DIGITS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .accept_o (accept),
    .step_o   (step),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  digit_shifter #(.DW(DIGIT_W), .ND(NUM_DIGITS)) u_opa (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept),
    .shift_i (step),
    .d_i     (a_i),
    .dig_o   (a_dig)
  );

  digit_shifter #(.DW(DIGIT_W), .ND(NUM_DIGITS)) u_opb (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept),
    .shift_i (step),
    .d_i     (b_i),
    .dig_o   (b_dig)
  );

  // Subtract: inverted subtrahend digit into the same adder.
  assign b_eff = (op_r == OP_SUB) ? ~b_dig : b_dig;

  digit_adder #(.DW(DIGIT_W)) u_add (
    .a_i (a_dig),
    .b_i (b_eff),
    .c_i (cy_r),
    .s_o (s_dig),
    .c_o (c_out)
  );

  always_comb begin
    op_n  = accept ? op_e'(sub_i) : op_r;
    cy_en = accept | step;
    cy_n  = accept ? sub_i : c_out;      // preset: 0 for add, 1 for subtract
    res_n = {s_dig, res_r[WIDTH-1:DIGIT_W]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_r  <= OP_ADD;
      cy_r  <= 1'b0;
      res_r <= '0;
    end else begin
      if (accept) op_r  <= op_n;
      if (cy_en)  cy_r  <= cy_n;
      if (step)   res_r <= res_n;
    end
  end

  assign sum_o   = res_r;
  assign cy_bw_o = cy_r ^ (op_r == OP_SUB);

  AST_CARRY_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> cy_r == $past(sub_i)); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=> op_r == $past(op_r)); // R7
  AST_SUM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> $stable(sum_o)); // R8
  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !start_i |=> $stable(cy_bw_o)); // R8
endmodule

// File: tb/tb_serial_addsub.sv
module tb_serial_addsub;
  localparam int SDW = 2;
  localparam int SND = 3;
  localparam int SW  = SDW * SND;
  localparam int LW  = 16;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_start = 1'b0, s_sub = 1'b0;
  logic [SW-1:0] s_a = '0, s_b = '0;
  logic s_busy, s_done, s_flag;
  logic [SW-1:0] s_sum;

  logic l_start = 1'b0, l_sub = 1'b0;
  logic [LW-1:0] l_a = '0, l_b = '0;
  logic l_busy, l_done, l_flag;
  logic [LW-1:0] l_sum;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  serial_addsub #(.DIGIT_W(SDW), .NUM_DIGITS(SND)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(s_start), .sub_i(s_sub),
    .a_i(s_a), .b_i(s_b), .busy_o(s_busy), .done_o(s_done),
    .sum_o(s_sum), .cy_bw_o(s_flag)
  );

  serial_addsub dut_w (
    .clk(clk), .rst_n(rst_n), .start_i(l_start), .sub_i(l_sub),
    .a_i(l_a), .b_i(l_b), .busy_o(l_busy), .done_o(l_done),
    .sum_o(l_sum), .cy_bw_o(l_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      failures++;
      $display("FAIL R2 watchdog expired actual=%0d expected<=%0d", cyc, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Small instance: full timing and value check of one operation.
  task automatic run_small(input logic [SW-1:0] a, input logic [SW-1:0] b,
                           input logic sub);
    logic [SW:0] ex;
    logic        ef;
    if (sub) begin
      ex = {1'b0, a} - {1'b0, b};
      ef = (a < b);
    end else begin
      ex = {1'b0, a} + {1'b0, b};
      ef = ex[SW];
    end
    @(negedge clk);
    s_a = a; s_b = b; s_sub = sub; s_start = 1'b1;
    @(negedge clk);
    s_start = 1'b0;
    for (int i = 0; i < SND; i++) begin
      if (i > 0) @(negedge clk);
      chk(s_busy && !s_done, "R2 busy per digit", {s_busy, s_done}, 2'b10);
    end
    @(negedge clk);
    chk(s_done && !s_busy, "R3 done after last digit", {s_busy, s_done}, 2'b01);
    if (sub) begin
      chk(s_sum == ex[SW-1:0], "R5 difference", s_sum, ex[SW-1:0]);
      chk(s_flag == ef, "R5 borrow", s_flag, ef);
    end else begin
      chk(s_sum == ex[SW-1:0], "R4 sum", s_sum, ex[SW-1:0]);
      chk(s_flag == ef, "R4 carry", s_flag, ef);
    end
    s_a = ~a; s_b = ~b; s_sub = ~sub;
    @(negedge clk);
    chk(!s_done, "R3 done single cycle", s_done, 1'b0);
    chk(s_sum == ex[SW-1:0] && s_flag == ef, "R8 result held",
        {s_flag, s_sum}, {ef, ex[SW-1:0]});
  endtask

  // Wide instance: start and wait for done.
  task automatic run_wide(input logic [LW-1:0] a, input logic [LW-1:0] b,
                          input logic sub, input logic [LW-1:0] exs,
                          input logic exf, input string req);
    @(negedge clk);
    l_a = a; l_b = b; l_sub = sub; l_start = 1'b1;
    @(negedge clk);
    l_start = 1'b0;
    for (int i = 0; i < 20 && !l_done; i++) @(negedge clk);
    chk(l_done, req, l_done, 1'b1);
    chk(l_sum == exs, req, l_sum, exs);
    chk(l_flag == exf, req, l_flag, exf);
  endtask

  initial begin
    s_start = 1'b1;
    l_start = 1'b1;
    repeat (3) @(negedge clk);
    chk(!s_busy && !s_done && s_sum == '0 && !s_flag, "R1 reset small",
        {s_busy, s_done, s_flag, 26'(s_sum)}, 0);
    chk(!l_busy && !l_done && l_sum == '0 && !l_flag, "R1 reset wide",
        {l_busy, l_done, l_flag, 16'(l_sum)}, 0);
    s_start = 1'b0;
    l_start = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!s_busy && !s_done && s_sum == '0 && !s_flag, "R1 after release",
        {s_busy, s_done, s_flag, 26'(s_sum)}, 0);

    // Exhaustive sweep on the small instance.
    for (int op = 0; op < 2; op++)
      for (int a = 0; a < (1 << SW); a++)
        for (int b = 0; b < (1 << SW); b++)
          run_small(SW'(a), SW'(b), op[0]);

    // R6: long chains and worked examples on the wide instance.
    run_wide(16'h20F4, 16'h0A18, 1'b1, 16'h16DC, 1'b0, "R6 sub example");
    run_wide(16'h2E83, 16'hA70F, 1'b0, 16'hD592, 1'b0, "R6 add example");
    run_wide(16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1, "R6 carry chain");
    run_wide(16'h0000, 16'h0001, 1'b1, 16'hFFFF, 1'b1, "R6 borrow chain");
    run_wide(16'h04A3, 16'h02FE, 1'b1, 16'h01A5, 1'b0, "R6 borrow through zero digit");
    run_wide(16'h2E86, 16'hA7FE, 1'b0, 16'hD684, 1'b0, "R6 carry through ones digit");
    run_wide(16'h1234, 16'h1234, 1'b1, 16'h0000, 1'b0, "R5 equal operands");

    // R7: start during busy is ignored.
    @(negedge clk);
    l_a = 16'h1234; l_b = 16'h1111; l_sub = 1'b0; l_start = 1'b1;
    @(negedge clk);
    l_a = 16'h0001; l_b = 16'h0F00; l_sub = 1'b1;
    @(negedge clk);
    @(negedge clk);
    l_start = 1'b0;
    @(negedge clk);
    chk(l_busy, "R7 still busy on normal schedule", l_busy, 1'b1);
    @(negedge clk);
    chk(l_done, "R7 done on normal schedule", l_done, 1'b1);
    chk(l_sum == 16'h2345 && !l_flag, "R7 first operation kept",
        {l_flag, l_sum}, {1'b0, 16'h2345});
    @(negedge clk);
    chk(!l_busy && !l_done, "R7 no restart", {l_busy, l_done}, 2'b00);

    // R8: hold across idle cycles with changing inputs.
    for (int i = 0; i < 5; i++) begin
      l_a = 16'(i * 4099); l_b = 16'(i * 77); l_sub = i[0];
      @(negedge clk);
    end
    chk(l_sum == 16'h2345 && !l_flag, "R8 held while idle",
        {l_flag, l_sum}, {1'b0, 16'h2345});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule